// File: doc/BRIEF.md
# Asynchronous Write Fault Recorder

This block watches transactions that a host issues towards an I/O bus and keeps a record of the first one that goes wrong. It knows three kinds of failure. A write can go unanswered for longer than 12.8 µs. A transaction can be answered with an error acknowledge. The bus can also report an error after a transaction has already finished. The block captures the kind of failure and the attributes of the failing transaction in a status word. For the first two kinds it also captures the transaction address in a fault-address word.

A single transaction is tracked at a time. A start strobe latches its address, size, direction and privilege level. An acknowledge or an error acknowledge ends it. Software reads both words through a small read port. A write strobe to the status word clears the record so that the next failure can be captured. Later failures that arrive while a record is held do not replace it. They only mark that more than one error happened.

Top module: `wfr_async_fault`

## Requirements
- R1: After reset the status word reads 0x00800000 and the fault-address word reads 0.
- R2: A write that receives neither an acknowledge nor an error acknowledge sets status bit 29. The fault becomes visible after the LIMIT-th rising edge that follows the start edge, where LIMIT is CLK_HZ × 12.8 µs (320 at the default 25 MHz). A response that arrives on the LIMIT-th edge is still in time, and no fault is recorded.
- R3: An error acknowledge to an outstanding read or write sets status bit 28.
- R4: A late-error strobe sets status bit 30 and takes its attributes from the most recently started transaction. It leaves bit 17 at 0 and the fault-address word unchanged.
- R5: Status bit 31 always equals the OR of bits 30, 29 and 28.
- R6: When a fault is captured, bits 27:25 hold the transaction size, bit 24 its supervisor flag and bit 18 its read flag. For timeout and error-acknowledge faults, bit 17 is set and the fault-address word holds the transaction address. reg_sel_i = 0 selects the status word and reg_sel_i = 1 selects the fault-address word.
- R7: Status bits 23:20 always read 0x8.
- R8: While a fault is recorded, further faults set bit 19 only and change no other status bit or the fault-address word.
- R9: A reg_clr_i pulse returns the status word to 0x00800000, which clears bit 17, and keeps the fault-address word. A fault in the same cycle as the clear is recorded as a first fault, with bit 19 at 0.
- R10: An acknowledged transaction records nothing. A read is never timed out. An acknowledge or error acknowledge with no transaction outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_start_i | input | 1 | Transaction start strobe |
| txn_addr_i | input | ADDR_W | Transaction address |
| txn_size_i | input | 3 | Transaction size code |
| txn_read_i | input | 1 | Transaction is a read |
| txn_super_i | input | 1 | Issuer in supervisor mode |
| ack_i | input | 1 | Normal acknowledge |
| err_ack_i | input | 1 | Error acknowledge |
| late_err_i | input | 1 | Error reported after completion |
| reg_sel_i | input | 1 | Read select: 0 status, 1 fault address |
| reg_clr_i | input | 1 | Write strobe to status: clears the record |
| reg_rdata_o | output | 32 | Selected register contents |

## Verification
The bench places a response on the last cycle before the timeout and checks that no fault appears. It then checks that a timeout appears exactly one edge after that cycle. An off-by-one counter would either flag the in-time write or report the fault a cycle late. Reads are left unanswered past the limit to catch a design that times out any transaction. A second fault is applied over a held record, and a fault is applied in the same cycle as a clear. A design that overwrites the first record, or loses the fault coinciding with the clear, shows the wrong fields or a stray bit 19. Late errors are checked for their attributes, for a clear bit 17 and for an unchanged fault address.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
  localparam logic [3:0] RESV_VAL = 4'h8;

  typedef struct packed {
    logic [2:0] size;
    logic       rd;
    logic       sup;
  } txn_attr_t;

  typedef struct packed {
    logic       le;
    logic       to;
    logic       be;
    logic [2:0] size;
    logic       sup;
    logic       me;
    logic       rd;
    logic       fav;
  } fault_rec_t;

  // 12.8 us equals 1/78125 s
  function automatic int unsigned timeout_cycles(int unsigned hz);
    int unsigned n;
    n = hz / 78125;
    return (n < 2) ? 2 : n;
  endfunction

  function automatic logic [31:0] pack_status(fault_rec_t r);
    return {(r.le | r.to | r.be), r.le, r.to, r.be, r.size, r.sup,
            RESV_VAL, r.me, r.rd, r.fav, 17'd0};
  endfunction
endpackage

// File: rtl/wfr_txn_track.sv
module wfr_txn_track
  import wfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIMIT  = 320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  txn_attr_t         attr_i,
  input  logic              ack_i,
  input  logic              err_ack_i,
  output txn_attr_t         attr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              to_evt_o,
  output logic              be_evt_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  txn_attr_t        attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic             resp;

  always_comb begin
    resp     = busy_q & (ack_i | err_ack_i);
    be_evt_o = busy_q & err_ack_i;
    to_evt_o = busy_q & ~attr_q.rd & ~ack_i & ~err_ack_i & (cnt_q == LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      attr_q <= '0;
      addr_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      attr_q <= attr_i;
      addr_q <= addr_i;
    end else if (busy_q) begin
      if (resp || to_evt_o) busy_q <= 1'b0;
      else if (!attr_q.rd)  cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign attr_o = attr_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/wfr_fault_log.sv
module wfr_fault_log
  import wfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              to_evt_i,
  input  logic              be_evt_i,
  input  logic              le_evt_i,
  input  txn_attr_t         attr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output fault_rec_t        rec_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  fault_rec_t        rec_q, rec_n;
  logic [ADDR_W-1:0] fa_q;
  logic              held, any_evt, take_addr;

  always_comb begin
    held      = (rec_q.le | rec_q.to | rec_q.be) & ~clr_i;
    any_evt   = to_evt_i | be_evt_i | le_evt_i;
    take_addr = any_evt & ~held & (to_evt_i | be_evt_i);
    rec_n     = clr_i ? '0 : rec_q;
    if (any_evt) begin
      if (held) begin
        rec_n.me = 1'b1;
      end else begin
        rec_n.le   = le_evt_i;
        rec_n.to   = to_evt_i;
        rec_n.be   = be_evt_i;
        rec_n.size = attr_i.size;
        rec_n.sup  = attr_i.sup;
        rec_n.rd   = attr_i.rd;
        rec_n.me   = 1'b0;
        rec_n.fav  = to_evt_i | be_evt_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
      fa_q  <= '0;
    end else begin
      rec_q <= rec_n;
      if (take_addr) fa_q <= addr_i;
    end
  end

  assign rec_o        = rec_q;
  assign fault_addr_o = fa_q;
endmodule

// File: rtl/wfr_reg_port.sv
module wfr_reg_port
  import wfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              sel_i,
  input  fault_rec_t        rec_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  output logic [31:0]       status_o,
  output logic [31:0]       rdata_o
);
  logic [31:0] addr_w;

  always_comb begin
    addr_w = '0;
    addr_w[ADDR_W-1:0] = fault_addr_i;
    status_o = pack_status(rec_i);
    rdata_o  = sel_i ? addr_w : status_o;
  end
endmodule

// File: rtl/wfr_async_fault.sv
module wfr_async_fault
  import wfr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 25_000_000,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic [2:0]        txn_size_i,
  input  logic              txn_read_i,
  input  logic              txn_super_i,
  input  logic              ack_i,
  input  logic              err_ack_i,
  input  logic              late_err_i,
  input  logic              reg_sel_i,
  input  logic              reg_clr_i,
  output logic [31:0]       reg_rdata_o
);
  localparam int unsigned LIMIT = timeout_cycles(CLK_HZ);

  txn_attr_t         in_attr, cur_attr;
  logic [ADDR_W-1:0] cur_addr, fault_addr;
  logic              to_evt, be_evt;
  fault_rec_t        rec;
  logic [31:0]       status_w;

  assign in_attr = '{size: txn_size_i, rd: txn_read_i, sup: txn_super_i};

  wfr_txn_track #(.ADDR_W(ADDR_W), .LIMIT(LIMIT)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (txn_start_i),
    .addr_i    (txn_addr_i),
    .attr_i    (in_attr),
    .ack_i     (ack_i),
    .err_ack_i (err_ack_i),
    .attr_o    (cur_attr),
    .addr_o    (cur_addr),
    .to_evt_o  (to_evt),
    .be_evt_o  (be_evt)
  );

  wfr_fault_log #(.ADDR_W(ADDR_W)) u_log (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (reg_clr_i),
    .to_evt_i     (to_evt),
    .be_evt_i     (be_evt),
    .le_evt_i     (late_err_i),
    .attr_i       (cur_attr),
    .addr_i       (cur_addr),
    .rec_o        (rec),
    .fault_addr_o (fault_addr)
  );

  wfr_reg_port #(.ADDR_W(ADDR_W)) u_regs (
    .sel_i        (reg_sel_i),
    .rec_i        (rec),
    .fault_addr_i (fault_addr),
    .status_o     (status_w),
    .rdata_o      (reg_rdata_o)
  );
endmodule

// File: rtl/wfr_async_fault_chk.sv
module wfr_async_fault_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] status_i,
  input logic        to_evt_i,
  input logic        be_evt_i,
  input logic        le_evt_i,
  input logic        ack_i,
  input logic        err_ack_i,
  input logic        reg_clr_i,
  input logic        reg_sel_i,
  input logic [31:0] reg_rdata_i
);
  logic any_evt;
  assign any_evt = to_evt_i | be_evt_i | le_evt_i;

  AST_SUMMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (reg_rdata_i[31] == |reg_rdata_i[30:28])); // R5
  AST_RESV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (reg_rdata_i[23:20] == 4'h8)); // R7
  AST_TO_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_evt_i |-> (!ack_i && !err_ack_i)); // R2
  AST_BE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_evt_i && (!status_i[31] || reg_clr_i)) |=> status_i[28]); // R3
  AST_FIRST_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[31] && !reg_clr_i) |=> (status_i[31:20] == $past(status_i[31:20])
                                      && status_i[18:17] == $past(status_i[18:17]))); // R8
  AST_MULTI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[31] && !reg_clr_i && any_evt) |=> status_i[19]); // R8
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_clr_i && !any_evt) |=> (status_i == 32'h0080_0000)); // R9
endmodule

bind wfr_async_fault wfr_async_fault_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .status_i    (status_w),
  .to_evt_i    (to_evt),
  .be_evt_i    (be_evt),
  .le_evt_i    (late_err_i),
  .ack_i       (ack_i),
  .err_ack_i   (err_ack_i),
  .reg_clr_i   (reg_clr_i),
  .reg_sel_i   (reg_sel_i),
  .reg_rdata_i (reg_rdata_o)
);

// File: tb/wfr_async_fault_bench.sv
module wfr_async_fault_bench;
  localparam int LIMIT = 320; // 12.8 us at 25 MHz

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rd = 0, sup = 0, ack = 0, eack = 0, late = 0, sel = 0, clr = 0;
  logic [31:0] addr = '0;
  logic [2:0]  size = '0;
  logic [31:0] rdata;
  int n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  wfr_async_fault u_wfr_async_fault (
    .clk_i(clk), .rst_ni(rst_n), .txn_start_i(start), .txn_addr_i(addr),
    .txn_size_i(size), .txn_read_i(rd), .txn_super_i(sup), .ack_i(ack),
    .err_ack_i(eack), .late_err_i(late), .reg_sel_i(sel), .reg_clr_i(clr),
    .reg_rdata_o(rdata)
  );

  function automatic logic [31:0] mk(logic le, logic to, logic be, logic [2:0] sz,
                                     logic s, logic me, logic r, logic fav);
    logic [31:0] w = 32'h0080_0000;
    w[31] = le | to | be; w[30] = le; w[29] = to; w[28] = be;
    w[27:25] = sz; w[24] = s; w[19] = me; w[18] = r; w[17] = fav;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic read_reg(logic s, output logic [31:0] v);
    sel = s; #1; v = rdata; sel = 0;
  endtask

  task automatic chk_stat(string tag, logic [31:0] exp);
    logic [31:0] v; read_reg(1'b0, v); chk(tag, v, exp);
  endtask

  task automatic chk_addr(string tag, logic [31:0] exp);
    logic [31:0] v; read_reg(1'b1, v); chk(tag, v, exp);
  endtask

  task automatic begin_txn(logic [31:0] a, logic [2:0] sz, logic r, logic s);
    addr = a; size = sz; rd = r; sup = s; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse_ack();  ack = 1;  @(negedge clk); ack = 0;  endtask
  task automatic pulse_eack(); eack = 1; @(negedge clk); eack = 0; endtask
  task automatic pulse_late(); late = 1; @(negedge clk); late = 0; endtask
  task automatic do_clear();   clr = 1;  @(negedge clk); clr = 0;  endtask

  // kind: 0 acked, 1 error ack, 2 no response, 3 late error after ack
  typedef struct packed {
    logic [1:0] kind; logic [2:0] sz; logic r; logic s; logic [31:0] a;
    logic le; logic to; logic be;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'd0, 3'd2, 1'b0, 1'b1, 32'h1000_0040, 1'b0, 1'b0, 1'b0},
    '{2'd1, 3'd3, 1'b0, 1'b0, 32'hFF00_1230, 1'b0, 1'b0, 1'b1},
    '{2'd1, 3'd1, 1'b1, 1'b1, 32'h8000_0004, 1'b0, 1'b0, 1'b1},
    '{2'd2, 3'd4, 1'b0, 1'b1, 32'hC0DE_0008, 1'b0, 1'b1, 1'b0},
    '{2'd3, 3'd5, 1'b0, 1'b0, 32'h0000_0ABC, 1'b1, 1'b0, 1'b0},
    '{2'd2, 3'd6, 1'b1, 1'b0, 32'h1234_5678, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_stat("R1 reset status", 32'h0080_0000);
    chk_addr("R1 reset address", 32'h0);

    for (int i = 0; i < 6; i++) begin
      vec_t v = VECS[i];
      do_clear();
      begin_txn(v.a, v.sz, v.r, v.s);
      case (v.kind)
        2'd0: begin repeat (2) @(negedge clk); pulse_ack(); end
        2'd1: begin repeat (2) @(negedge clk); pulse_eack(); end
        2'd2: begin repeat (LIMIT) @(negedge clk); if (v.r) pulse_ack(); end
        default: begin pulse_ack(); repeat (2) @(negedge clk); pulse_late(); end
      endcase
      // R3 R4 R5 R6 R10 covered by table rows
      chk_stat($sformatf("R6 vector %0d status", i),
               mk(v.le, v.to, v.be, (v.le|v.to|v.be) ? v.sz : 3'd0,
                  (v.le|v.to|v.be) ? v.s : 1'b0, 1'b0,
                  (v.le|v.to|v.be) ? v.r : 1'b0, v.to | v.be));
      if (v.to | v.be) chk_addr($sformatf("R6 vector %0d address", i), v.a);
    end

    // R2 timeout boundary
    do_clear();
    begin_txn(32'hAAAA_0000, 3'd2, 1'b0, 1'b0);
    repeat (LIMIT - 1) @(negedge clk);
    pulse_ack();
    chk_stat("R2 ack on last cycle in time", 32'h0080_0000);
    begin_txn(32'hBBBB_0010, 3'd7, 1'b0, 1'b1);
    repeat (LIMIT - 1) @(negedge clk);
    chk_stat("R2 no fault one edge early", 32'h0080_0000);
    @(negedge clk);
    chk_stat("R2 timeout after limit", mk(0, 1, 0, 3'd7, 1, 0, 0, 1));
    chk_addr("R2 timeout address", 32'hBBBB_0010);

    // R8 first fault kept
    begin_txn(32'hCCCC_0020, 3'd1, 1'b1, 1'b0);
    pulse_eack();
    chk_stat("R8 second fault sets only ME", mk(0, 1, 0, 3'd7, 1, 1, 0, 1));
    chk_addr("R8 address kept", 32'hBBBB_0010);

    // R9 clear coinciding with late error; R4 address unchanged
    clr = 1; late = 1; @(negedge clk); clr = 0; late = 0;
    chk_stat("R9 fault with clear is first", mk(1, 0, 0, 3'd1, 0, 0, 1, 0));
    chk_addr("R4 late error keeps address", 32'hBBBB_0010);
    do_clear();
    chk_stat("R9 clear restores status", 32'h0080_0000);
    chk_addr("R9 clear keeps address", 32'hBBBB_0010);

    // R10 responses while idle
    pulse_eack();
    pulse_ack();
    chk_stat("R10 idle error ack ignored", 32'h0080_0000);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100_000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule